// File: doc/BRIEF.md
# Watchdog Timer with Interrupt-Then-Reset Escalation

This peripheral watches for software that has stopped making progress. A free-running counter advances on a selectable watchdog clock. That clock is either every cycle of the main clock or only the cycles on which an alternate slow-clock enable pulses. When the counter wraps, the block raises a time-out flag and, if enabled, an interrupt request. If a reset is enabled and software fails to restart the watchdog within a fixed grace window, the block issues a one-cycle system reset pulse. Software talks to it through one 8-bit control/status register on a simple write-strobe bus, with a read port that always shows the register.

The block also records the cause of a reset. A power-on flag, a watchdog-reset flag and the reset-enable bit each follow their own rule for power-on, external and watchdog resets. This lets software tell after a restart why it is running.

The escalation is sequenced by a three-state machine. RUN is the normal counting state. GRACE is entered from RUN on a time-out while reset-enable is 1. GRACE returns to RUN when a restart is written (cancel), or when the grace window ends with reset-enable cleared (abandon). GRACE moves to FIRE when the window ends with reset-enable still 1 (expire). FIRE drives the reset pulse for one cycle and always returns to RUN (apply). A power-on or external reset forces RUN from any state.

Top module: `wdog_staged_reset`

## Requirements
- R1: Register layout. bit 6 = power-on flag, bit 4 = clock select, bit 3 = time-out flag, bit 2 = watchdog-reset flag, bit 1 = reset enable, bit 0 = restart. Bits 7 and 5 read 0, and bit 0 always reads 0.
- R2: With clock select 0 the counter advances every clock; with 1 it advances only on cycles where `slow_tick_i` is 1. A time-out occurs on the 2^CNT_W-th counted tick after a restart, and the counter then wraps and keeps counting.
- R3: A time-out sets the time-out flag. Writing 0 to bit 3 clears it and writing 1 leaves it unchanged. A time-out in the same cycle as a clearing write leaves it set. Any reset clears it.
- R4: `irq_o` is 1 exactly when the time-out flag, `wdi_en_i` and `gie_i` are all 1.
- R5: A write with bit 0 = 1 returns the count to zero. A restart sampled on the same edge as the final counted tick suppresses that time-out.
- R6: With reset enable 1, `wdt_rst_o` is a registered pulse, exactly one clock wide. It becomes visible GRACE_TICKS watchdog ticks after the time-out edge (512 clocks with clock select 0).
- R7: If reset enable is 0 when the grace window ends, no reset pulse is produced. The watchdog-reset flag is only ever set by a reset pulse.
- R8: A restart during the grace window cancels the pending reset and restarts the main count.
- R9: A power-on reset sets the power-on flag and clears the watchdog-reset flag, reset enable, clock select and time-out flag. The power-on flag and watchdog-reset flag are cleared only by writing 0 to their bits; writing 1 has no effect.
- R10: An external reset clears clock select and the time-out flag and restarts the count. It leaves the power-on flag, watchdog-reset flag and reset enable unchanged.
- R11: On the clock after the reset pulse, the watchdog-reset flag is 1, the time-out flag and clock select are 0, and the count restarts. The power-on flag and reset enable are unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Main oscillator clock |
| por_i | input | 1 | Power-on / power-fail reset, synchronous, active high |
| ext_rst_i | input | 1 | External reset, synchronous, active high |
| slow_tick_i | input | 1 | Alternate slow clock as a one-cycle enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_data_i | input | 8 | Register write data |
| rd_data_o | output | 8 | Register read value |
| wdi_en_i | input | 1 | Watchdog interrupt enable from the interrupt controller |
| gie_i | input | 1 | Global interrupt enable |
| irq_o | output | 1 | Watchdog interrupt request |
| wdt_rst_o | output | 1 | One-cycle watchdog system reset pulse |

## Verification
Two pairs of events can coincide. A restart can land on the final counted tick, and a time-out can land in the same cycle as a software write clearing the time-out flag. The bench counts exactly 1024 clocks from a restart (CNT_W = 10) and places a write on that edge. For the restart, no flag may appear there and the next time-out must come exactly one period later. For the clearing write, the flag must stay set. A long random phase with a fixed seed mixes random writes, restarts, resets and slow-tick patterns. In that phase every cycle is compared against a bench model built from the requirements, so further collisions, including restarts inside the grace window, are judged on the same terms.

// File: rtl/wdsr_pkg.sv
package wdsr_pkg;
    typedef enum logic [1:0] {
        ST_RUN   = 2'd0,
        ST_GRACE = 2'd1,
        ST_FIRE  = 2'd2
    } wd_state_e;

    localparam int BIT_RESTART  = 0;
    localparam int BIT_RST_EN   = 1;
    localparam int BIT_RST_FLAG = 2;
    localparam int BIT_TMO_FLAG = 3;
    localparam int BIT_CLK_SEL  = 4;
    localparam int BIT_PON_FLAG = 6;
endpackage

// File: rtl/wdsr_tick_sel.sv
module wdsr_tick_sel (
    input  logic sel_i,
    input  logic slow_tick_i,
    output logic tick_o
);
    always_comb begin
        tick_o = sel_i ? slow_tick_i : 1'b1;
    end
endmodule

// File: rtl/wdsr_counter.sv
module wdsr_counter #(
    parameter int CNT_W = 17
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic clr_i,
    input  logic tick_i,
    output logic timeout_o
);
    localparam logic [CNT_W-1:0] CNT_LAST = '1;

    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk_i) begin
        if (clr_i) begin
            cnt_q <= '0;
        end else if (tick_i) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign timeout_o = tick_i && !clr_i && (cnt_q == CNT_LAST);

    AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (rst_i)
        clr_i |=> (cnt_q == '0)); // R5
    AST_TMO_WRAPS: assert property (@(posedge clk_i) disable iff (rst_i)
        timeout_o |=> (cnt_q == '0)); // R2
endmodule

// File: rtl/wdsr_fsm.sv
module wdsr_fsm
    import wdsr_pkg::*;
#(
    parameter int GRACE_TICKS = 512
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic restart_i,
    input  logic tick_i,
    input  logic timeout_i,
    input  logic rst_en_i,
    output logic wdt_rst_o
);
    localparam int GC_W = (GRACE_TICKS > 1) ? $clog2(GRACE_TICKS) : 1;
    localparam logic [GC_W-1:0] GC_LAST = GC_W'(GRACE_TICKS - 1);

    wd_state_e       state_q, state_d;
    logic [GC_W-1:0] gcnt_q, gcnt_d;
    logic            fire_q;

    always_comb begin
        state_d = state_q;
        gcnt_d  = gcnt_q;
        unique case (state_q)
            ST_RUN: begin
                if (timeout_i && rst_en_i) begin
                    state_d = ST_GRACE;
                    gcnt_d  = '0;
                end
            end
            ST_GRACE: begin
                if (restart_i) begin
                    state_d = ST_RUN;
                end else if (tick_i) begin
                    if (gcnt_q == GC_LAST) begin
                        state_d = rst_en_i ? ST_FIRE : ST_RUN;
                    end else begin
                        gcnt_d = gcnt_q + 1'b1;
                    end
                end
            end
            ST_FIRE: begin
                state_d = ST_RUN;
            end
            default: begin
                state_d = ST_RUN;
            end
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            state_q <= ST_RUN;
            gcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            gcnt_q  <= gcnt_d;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            fire_q <= 1'b0;
        end else begin
            fire_q <= (state_d == ST_FIRE);
        end
    end

    assign wdt_rst_o = fire_q;

    AST_PULSE_ONE_WIDE: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |=> !wdt_rst_o); // R6
    AST_PULSE_AFTER_GRACE: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |-> ($past(state_q) == ST_GRACE && $past(gcnt_q) == GC_LAST)); // R6
    AST_PULSE_NEEDS_EN: assert property (@(posedge clk_i) disable iff (rst_i)
        wdt_rst_o |-> $past(rst_en_i)); // R7
    AST_RESTART_CANCELS: assert property (@(posedge clk_i) disable iff (rst_i)
        (state_q == ST_GRACE && restart_i) |=> !wdt_rst_o); // R8
endmodule

// File: rtl/wdsr_regs.sv
module wdsr_regs
    import wdsr_pkg::*;
(
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       ext_i,
    input  logic       wdt_fire_i,
    input  logic       timeout_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic       restart_o,
    output logic       sel_o,
    output logic       rst_en_o,
    output logic       tmo_flag_o,
    output logic [7:0] rd_data_o
);
    logic pon_q, pon_d;
    logic sel_q, sel_d;
    logic tmo_q, tmo_d;
    logic rfl_q, rfl_d;
    logic ren_q, ren_d;
    logic unused_wr_bits;

    assign unused_wr_bits = wr_data_i[7] ^ wr_data_i[5];

    always_comb begin
        pon_d = pon_q;
        sel_d = sel_q;
        tmo_d = tmo_q;
        rfl_d = rfl_q;
        ren_d = ren_q;
        if (por_i) begin
            pon_d = 1'b1;
            sel_d = 1'b0;
            tmo_d = 1'b0;
            rfl_d = 1'b0;
            ren_d = 1'b0;
        end else if (ext_i) begin
            sel_d = 1'b0;
            tmo_d = 1'b0;
        end else if (wdt_fire_i) begin
            sel_d = 1'b0;
            tmo_d = 1'b0;
            rfl_d = 1'b1;
        end else begin
            if (wr_en_i) begin
                sel_d = wr_data_i[BIT_CLK_SEL];
                ren_d = wr_data_i[BIT_RST_EN];
                if (!wr_data_i[BIT_TMO_FLAG]) tmo_d = 1'b0;
                if (!wr_data_i[BIT_RST_FLAG]) rfl_d = 1'b0;
                if (!wr_data_i[BIT_PON_FLAG]) pon_d = 1'b0;
            end
            if (timeout_i) begin
                tmo_d = 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i) begin
        pon_q <= pon_d;
        sel_q <= sel_d;
        tmo_q <= tmo_d;
        rfl_q <= rfl_d;
        ren_q <= ren_d;
    end

    assign restart_o  = wr_en_i && wr_data_i[BIT_RESTART];
    assign sel_o      = sel_q;
    assign rst_en_o   = ren_q;
    assign tmo_flag_o = tmo_q;

    always_comb begin
        rd_data_o               = 8'h00;
        rd_data_o[BIT_PON_FLAG] = pon_q;
        rd_data_o[BIT_CLK_SEL]  = sel_q;
        rd_data_o[BIT_TMO_FLAG] = tmo_q;
        rd_data_o[BIT_RST_FLAG] = rfl_q;
        rd_data_o[BIT_RST_EN]   = ren_q;
    end

    AST_TMO_SETS_FLAG: assert property (@(posedge clk_i) disable iff (por_i)
        (timeout_i && !ext_i && !wdt_fire_i) |=> tmo_q); // R3
    AST_RFLAG_ONLY_BY_PULSE: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(rfl_q) |-> $past(wdt_fire_i)); // R7
    AST_PON_ONLY_BY_POR: assert property (@(posedge clk_i) disable iff (por_i)
        $rose(pon_q) |-> $past(por_i)); // R9
    AST_EXT_KEEPS_CAUSE: assert property (@(posedge clk_i) disable iff (por_i)
        ext_i |=> (rfl_q == $past(rfl_q) && ren_q == $past(ren_q) && pon_q == $past(pon_q))); // R10
    AST_FIRE_MARKS_CAUSE: assert property (@(posedge clk_i) disable iff (por_i)
        (wdt_fire_i && !ext_i) |=> (rfl_q && !tmo_q && !sel_q)); // R11
endmodule

// File: rtl/wdog_staged_reset.sv
module wdog_staged_reset
    import wdsr_pkg::*;
#(
    parameter int CNT_W       = 17,
    parameter int GRACE_TICKS = 512
) (
    input  logic       clk_i,
    input  logic       por_i,
    input  logic       ext_rst_i,
    input  logic       slow_tick_i,
    input  logic       wr_en_i,
    input  logic [7:0] wr_data_i,
    output logic [7:0] rd_data_o,
    input  logic       wdi_en_i,
    input  logic       gie_i,
    output logic       irq_o,
    output logic       wdt_rst_o
);
    logic tick;
    logic restart;
    logic sel;
    logic rst_en;
    logic tmo_flag;
    logic timeout;
    logic fire;
    logic seq_rst;
    logic cnt_clr;

    assign seq_rst = por_i || ext_rst_i;
    assign cnt_clr = seq_rst || fire || restart;

    wdsr_regs u_regs (
        .clk_i      (clk_i),
        .por_i      (por_i),
        .ext_i      (ext_rst_i),
        .wdt_fire_i (fire),
        .timeout_i  (timeout),
        .wr_en_i    (wr_en_i),
        .wr_data_i  (wr_data_i),
        .restart_o  (restart),
        .sel_o      (sel),
        .rst_en_o   (rst_en),
        .tmo_flag_o (tmo_flag),
        .rd_data_o  (rd_data_o)
    );

    wdsr_tick_sel u_tick (
        .sel_i       (sel),
        .slow_tick_i (slow_tick_i),
        .tick_o      (tick)
    );

    wdsr_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk_i     (clk_i),
        .rst_i     (seq_rst),
        .clr_i     (cnt_clr),
        .tick_i    (tick),
        .timeout_o (timeout)
    );

    wdsr_fsm #(.GRACE_TICKS(GRACE_TICKS)) u_fsm (
        .clk_i     (clk_i),
        .rst_i     (seq_rst),
        .restart_i (restart),
        .tick_i    (tick),
        .timeout_i (timeout),
        .rst_en_i  (rst_en),
        .wdt_rst_o (fire)
    );

    assign irq_o     = tmo_flag && wdi_en_i && gie_i;
    assign wdt_rst_o = fire;
endmodule

// File: tb/wdog_staged_reset_tb.sv
module wdog_staged_reset_tb;
    localparam int CNT_W  = 10;
    localparam int PERIOD = 1 << CNT_W;
    localparam int GRACE  = 512;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       ext_rst = 1'b0;
    logic       slow_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       wdi_en = 1'b0;
    logic       gie = 1'b0;
    logic       irq;
    logic       wdt_rst;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    bit tick_rand = 1'b0;
    int div = 0;

    always #10 clk = ~clk;

    wdog_staged_reset #(.CNT_W(CNT_W), .GRACE_TICKS(GRACE)) u_dut (
        .clk_i(clk), .por_i(por), .ext_rst_i(ext_rst), .slow_tick_i(slow_tick),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_data_o(rd_data),
        .wdi_en_i(wdi_en), .gie_i(gie), .irq_o(irq), .wdt_rst_o(wdt_rst)
    );

    // Slow tick source: exact 1-in-4 pattern or random.
    always @(negedge clk) begin
        if (tick_rand) begin
            slow_tick = (($urandom % 3) == 0);
        end else begin
            slow_tick = (div == 0);
            div = (div + 1) % 4;
        end
    end

    // Requirement-level model: RUN=0, GRACE=1, FIRE=2.
    int m_cnt = 0, m_gc = 0, m_st = 0;
    bit m_pon = 0, m_sel = 0, m_tf = 0, m_rf = 0, m_en = 0;
    always @(posedge clk) begin
        bit tk, rs, to;
        tk = m_sel ? slow_tick : 1'b1;
        rs = wr_en && wr_data[0];
        if (por) begin
            m_pon = 1; m_rf = 0; m_en = 0; m_sel = 0; m_tf = 0; m_cnt = 0; m_st = 0; m_gc = 0;
        end else if (ext_rst) begin
            m_sel = 0; m_tf = 0; m_cnt = 0; m_st = 0; m_gc = 0;
        end else if (m_st == 2) begin
            m_sel = 0; m_tf = 0; m_rf = 1; m_cnt = 0; m_st = 0; m_gc = 0;
        end else begin
            to = !rs && tk && (m_cnt == PERIOD - 1);
            if (m_st == 1) begin
                if (rs) m_st = 0;
                else if (tk) begin
                    if (m_gc == GRACE - 1) m_st = m_en ? 2 : 0;
                    else m_gc++;
                end
            end else if (to && m_en) begin
                m_st = 1; m_gc = 0;
            end
            if (rs) m_cnt = 0;
            else if (tk) m_cnt = (m_cnt + 1) % PERIOD;
            if (wr_en) begin
                m_sel = wr_data[4]; m_en = wr_data[1];
                if (!wr_data[3]) m_tf = 0;
                if (!wr_data[2]) m_rf = 0;
                if (!wr_data[6]) m_pon = 0;
            end
            if (to) m_tf = 1;
        end
    end

    function automatic logic [7:0] model_rd();
        return {1'b0, m_pon, 1'b0, m_sel, m_tf, m_rf, m_en, 1'b0};
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=%0d expected=<190000 cycles", cyc);
            summary();
        end
    end

    task automatic wr(input logic [7:0] d);
        wr_en = 1'b1; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = 8'h00;
    endtask

    task automatic wait_tflag(output int n);
        n = 0;
        while (!rd_data[3] && n < 20000) begin @(negedge clk); n++; end
    endtask

    task automatic to_pulse(input int lim, output int n);
        n = 0;
        while (!wdt_rst && n < lim) begin @(negedge clk); n++; end
    endtask

    initial begin
        int n;
        void'($urandom(32'h5EED_0625));
        repeat (3) @(negedge clk);
        por = 1'b0;
        @(negedge clk);
        chk("R9 por state", rd_data, 8'h40);
        chk("R1 reset outputs", {irq, wdt_rst}, 0);

        wr(8'h4C);
        chk("R9 write-1 to flags ignored", rd_data, 8'h40);

        // Restart then collide a second restart with the final tick.
        wr(8'h43);
        chk("R1 restart reads 0", rd_data, 8'h42);
        repeat (PERIOD - 1) @(negedge clk);
        wr(8'h43);
        chk("R5 restart on final tick suppresses time-out", rd_data[3], 0);
        repeat (PERIOD - 1) @(negedge clk);
        chk("R2 no time-out one tick early", rd_data[3], 0);
        @(negedge clk);
        chk("R2 time-out at 2^CNT_W ticks", rd_data[3], 1);
        to_pulse(2000, n);
        chk("R6 grace length in clocks", n, GRACE);
        @(negedge clk);
        chk("R6 pulse one clock wide", wdt_rst, 0);
        chk("R11 state after watchdog reset", rd_data, 8'h46);

        // External reset.
        wr(8'h56);
        chk("R1 sel readback", rd_data, 8'h56);
        ext_rst = 1'b1; @(negedge clk); ext_rst = 1'b0;
        chk("R10 external reset keeps cause bits", rd_data, 8'h46);

        wr(8'h02);
        chk("R9 software clears power-on flag", rd_data, 8'h02);

        // Reset enable off: interrupt only.
        wr(8'h01);
        chk("R7 reset enable off", rd_data, 8'h00);
        wait_tflag(n);
        chk("R3 time-out sets flag", rd_data, 8'h08);
        for (int k = 0; k < 4; k++) begin
            wdi_en = k[0]; gie = k[1];
            #1;
            chk("R4 irq gating", irq, k[0] & k[1]);
        end
        wdi_en = 1'b0; gie = 1'b0;
        to_pulse(600, n);
        chk("R7 no pulse with enable off", n, 600);
        chk("R7 reset flag stays clear", rd_data, 8'h08);
        wr(8'h00);
        chk("R3 software clears flag", rd_data, 8'h00);

        // Enable dropped during grace window.
        wr(8'h03);
        wait_tflag(n);
        wr(8'h08);
        to_pulse(600, n);
        chk("R7 enable cleared in grace: no pulse", n, 600);
        chk("R7 flags after abandoned grace", rd_data, 8'h08);

        // Restart inside grace window.
        wr(8'h03);
        wait_tflag(n);
        repeat (300) @(negedge clk);
        wr(8'h0B);
        to_pulse(600, n);
        chk("R8 restart in grace cancels reset", n, 600);
        chk("R8 flags after cancel", rd_data, 8'h0A);

        // Slow clock: grace counted in slow ticks (1 in 4 clocks).
        wr(8'h13);
        wait_tflag(n);
        chk("R2 slow clock period", (n >= PERIOD * 4 - 4) && (n <= PERIOD * 4 + 4), 1);
        to_pulse(5000, n);
        chk("R6 grace in slow ticks", n, GRACE * 4);
        @(negedge clk);
        chk("R11 sel cleared, reset flag set", rd_data, 8'h06);

        // Time-out collides with a clearing write.
        wr(8'h01);
        repeat (PERIOD - 1) @(negedge clk);
        wr(8'h00);
        chk("R3 time-out wins over same-cycle clear", rd_data[3], 1);
        por = 1'b1; @(negedge clk); por = 1'b0;
        chk("R3 R9 power-on reset clears flag", rd_data, 8'h40);

        // Random phase against the model.
        tick_rand = 1'b1;
        for (int i = 0; i < 40000; i++) begin
            int r;
            @(negedge clk);
            chk("R1 R2 R3 R4 R5 R6 R8 R10 R11 random rd", rd_data, model_rd());
            chk("R4 random irq", irq, m_tf & wdi_en & gie);
            chk("R6 R7 random pulse", wdt_rst, m_st == 2);
            r = $urandom % 1000;
            por = (r == 0);
            ext_rst = (r == 1 || r == 2);
            wr_en = (r >= 3 && r < 5);
            wr_data = 8'($urandom);
            wdi_en = $urandom % 2;
            gie = $urandom % 2;
        end
        por = 1'b0; ext_rst = 1'b0; wr_en = 1'b0;
        summary();
    end
endmodule